// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits and returns their signed product of `2*WIDTH` bits. It uses radix-2 Booth recoding and performs one iteration per clock. At each iteration it reads the lowest multiplier bit together with a history bit kept to its right. Depending on that pair, it adds the multiplicand to the accumulator, subtracts it, or leaves the accumulator unchanged. An arithmetic right shift of the whole accumulator/multiplier/history chain then follows.

A one-cycle `start` pulse loads both operands while the block is idle. After exactly `WIDTH` iterations, `done` pulses for one cycle. The product, formed from the low half of the accumulator and the multiplier register, stays on `product` until the next accepted start. A `start` that arrives while an operation is running is dropped. The accumulator carries one guard bit above `WIDTH`. This keeps every operand pair exact, including the pair in which both operands are the most negative value.

Top module: `booth_mult`

## Requirements
- R1: A `start` sampled high while idle loads `op_mplier` into the multiplier register and `op_mcand` into the multiplicand register. The same edge clears the accumulator and the history bit and sets the iteration counter to `WIDTH`. A `start` on the cycle in which `done` is high is accepted.
- R2: When the pair {multiplier bit 0, history bit} is 00 or 11, the accumulator is not changed before the shift.
- R3: When the pair is 01, the multiplicand is added to the accumulator before the shift.
- R4: When the pair is 10, the multiplicand is subtracted from the accumulator before the shift.
- R5: Every iteration shifts {accumulator, multiplier, history} right by one bit. The accumulator's sign bit is kept, the accumulator's bit 0 enters the multiplier's top bit, and the multiplier's bit 0 becomes the history bit.
- R6: If `start` is accepted at clock edge k, the iterations take place at edges k+1 to k+WIDTH. `done` is high during the cycle that follows edge k+WIDTH, and at that time `product` equals the signed product of the two operands.
- R7: `done` is high for exactly one cycle per operation.
- R8: While idle and without an accepted start, `product` holds its value.
- R9: The most negative value times itself, and the most negative value times the most positive value, both give exact `2*WIDTH`-bit results. The add and subtract are done in `WIDTH+1` bits.
- R10: A `start` sampled while an operation is running has no effect on its result or its timing.
- R11: A synchronous active-low reset clears `done` and `product` to zero and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Load operands and begin, when idle |
| op_mcand | input | WIDTH | Signed multiplicand |
| op_mplier | input | WIDTH | Signed multiplier |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2*WIDTH | Signed product |

## Verification
The bench applies `start` at a falling edge, so the load happens at the next rising edge k. It then expects `done`, with the finished product, in the cycle after edge k+WIDTH, which is WIDTH+1 cycles after the load edge. A behavioural model in the bench advances on every rising edge. It keeps its own counter and result, computed with a plain signed multiply. At every falling edge the bench compares `done` against the model. It also compares `product` whenever the model holds a finished or reset value. This catches an early or late `done`, a double pulse, a result that drifts while idle, and a start wrongly accepted mid-run. The per-iteration arithmetic for the pairs 00/11, 01 and 10 is checked one edge after each iteration by the bound assertions.

// File: rtl/booth_pkg.sv
// Shared types for the Booth multiplier.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package booth_pkg;

    // Arithmetic action chosen by the recoded bit pair
    typedef enum logic [1:0] {
        BOP_HOLD = 2'b00,
        BOP_ADD  = 2'b01,
        BOP_SUB  = 2'b10
    } booth_op_e;

endpackage

// File: rtl/booth_recode.sv
// Radix-2 Booth recoder: maps {multiplier bit 0, history bit} to an action.
// Assumes: purely combinational; 01 adds, 10 subtracts, 00/11 hold.
module booth_recode
    import booth_pkg::*;
(
    input  logic      q_lsb,
    input  logic      q_hist,
    output booth_op_e op
);

    // Decode the bit pair into an add, subtract or hold action
    always_comb begin
        case ({q_lsb, q_hist})
            2'b01:   op = BOP_ADD;
            2'b10:   op = BOP_SUB;
            default: op = BOP_HOLD;
        endcase
    end

endmodule

// File: rtl/booth_step.sv
// One Booth iteration: optional add/subtract of the multiplicand on a
// WIDTH+1 bit accumulator, then an arithmetic right shift of the
// {accumulator, multiplier, history} chain.
// Assumes: WIDTH >= 2; carry out of the guarded accumulator is dropped.
module booth_step
    import booth_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH:0]   acc,
    input  logic [WIDTH-1:0] mplr,
    input  logic [WIDTH-1:0] mcand,
    input  booth_op_e        op,
    output logic [WIDTH:0]   acc_nx,
    output logic [WIDTH-1:0] mplr_nx,
    output logic             hist_nx
);

    localparam int AW = WIDTH + 1;

    logic [AW-1:0] mcand_ext;
    logic [AW-1:0] sum;

    // Sign-extend the multiplicand into the guarded width
    assign mcand_ext = {mcand[WIDTH-1], mcand};

    // Apply the chosen action to the accumulator
    always_comb begin
        case (op)
            BOP_ADD: sum = acc + mcand_ext;
            BOP_SUB: sum = acc - mcand_ext;
            default: sum = acc;
        endcase
    end

    // Arithmetic right shift across the whole chain
    always_comb begin
        acc_nx  = {sum[AW-1], sum[AW-1:1]};
        mplr_nx = {sum[0], mplr[WIDTH-1:1]};
        hist_nx = mplr[0];
    end

endmodule

// File: rtl/booth_seq.sv
// Sequencer: accepts start when idle, counts WIDTH iterations down,
// and pulses done after the last one.
// Assumes: start while busy is ignored; busy means count is non-zero.
module booth_seq #(
    parameter int WIDTH = 8,
    localparam int CW   = $clog2(WIDTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          load,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] count
);

    assign busy = (count != '0);
    assign load = start && !busy;

    // Iteration counter and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            done  <= 1'b0;
        end else begin
            done <= busy && (count == CW'(1));
            if (load) begin
                count <= CW'(WIDTH);
            end else if (busy) begin
                count <= count - CW'(1);
            end
        end
    end

endmodule

// File: rtl/booth_mult.sv
// Sequential radix-2 Booth multiplier for signed WIDTH-bit operands.
// One iteration per clock; product valid with the done pulse and held
// until the next accepted start.
// Assumes: synchronous active-low reset; product shows partial values
// while an operation runs.
module booth_mult
    import booth_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WIDTH-1:0]   op_mcand,
    input  logic [WIDTH-1:0]   op_mplier,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);

    localparam int AW = WIDTH + 1;
    localparam int CW = $clog2(WIDTH + 1);

    logic [AW-1:0]    acc_q;
    logic [WIDTH-1:0] mplr_q;
    logic             hist_q;
    logic [WIDTH-1:0] mcand_q;

    logic [AW-1:0]    acc_nx;
    logic [WIDTH-1:0] mplr_nx;
    logic             hist_nx;
    booth_op_e        step_op;
    logic             load;
    logic             busy;
    logic [CW-1:0]    count;

    booth_seq #(.WIDTH(WIDTH)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .busy  (busy),
        .done  (done),
        .count (count)
    );

    booth_recode u_recode (
        .q_lsb  (mplr_q[0]),
        .q_hist (hist_q),
        .op     (step_op)
    );

    booth_step #(.WIDTH(WIDTH)) u_step (
        .acc     (acc_q),
        .mplr    (mplr_q),
        .mcand   (mcand_q),
        .op      (step_op),
        .acc_nx  (acc_nx),
        .mplr_nx (mplr_nx),
        .hist_nx (hist_nx)
    );

    // Datapath registers: load operands or advance one iteration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            mplr_q  <= '0;
            hist_q  <= 1'b0;
            mcand_q <= '0;
        end else if (load) begin
            acc_q   <= '0;
            mplr_q  <= op_mplier;
            hist_q  <= 1'b0;
            mcand_q <= op_mcand;
        end else if (busy) begin
            acc_q   <= acc_nx;
            mplr_q  <= mplr_nx;
            hist_q  <= hist_nx;
        end
    end

    assign product = {acc_q[WIDTH-1:0], mplr_q};

endmodule

// File: rtl/booth_mult_chk.sv
// Assertion checker for booth_mult, attached by bind.
// Assumes: sees the top's internal registers through its port list.
module booth_mult_chk #(
    parameter int WIDTH = 8,
    localparam int AW   = WIDTH + 1,
    localparam int CW   = $clog2(WIDTH + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [WIDTH-1:0]   op_mcand,
    input logic [WIDTH-1:0]   op_mplier,
    input logic               busy,
    input logic [CW-1:0]      count,
    input logic [AW-1:0]      acc,
    input logic [WIDTH-1:0]   mplr,
    input logic               hist,
    input logic [WIDTH-1:0]   mcand,
    input logic               done,
    input logic [2*WIDTH-1:0] product
);

    logic [AW-1:0] ref_add;
    logic [AW-1:0] ref_sub;

    // Independent guarded sums for the add/subtract checks
    assign ref_add = acc + {mcand[WIDTH-1], mcand};
    assign ref_sub = acc - {mcand[WIDTH-1], mcand};

    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> acc == '0 && !hist && mplr == $past(op_mplier)
                           && mcand == $past(op_mcand) && count == CW'(WIDTH)); // R1
    AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (mplr[0] == hist) |=> acc == {$past(acc[AW-1]), $past(acc[AW-1:1])}); // R2
    AST_PAIR_ADD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !mplr[0] && hist |=> acc == {$past(ref_add[AW-1]), $past(ref_add[AW-1:1])}); // R3
    AST_PAIR_SUB: assert property (@(posedge clk) disable iff (!rst_n)
        busy && mplr[0] && !hist |=> acc == {$past(ref_sub[AW-1]), $past(ref_sub[AW-1:1])}); // R4
    AST_SHIFT_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> hist == $past(mplr[0]) && mplr[WIDTH-2:0] == $past(mplr[WIDTH-1:1])); // R5
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        busy && count == CW'(1) |=> done && !busy); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(product)); // R8
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(mcand) && count == $past(count) - CW'(1)); // R10

endmodule

bind booth_mult booth_mult_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op_mcand  (op_mcand),
    .op_mplier (op_mplier),
    .busy      (busy),
    .count     (count),
    .acc       (acc_q),
    .mplr      (mplr_q),
    .hist      (hist_q),
    .mcand     (mcand_q),
    .done      (done),
    .product   (product)
);

// File: tb/booth_mult_tb.sv
`timescale 1ns/1ps
module booth_mult_tb;

    localparam int W = 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic signed [W-1:0] a = '0;
    logic signed [W-1:0] b = '0;
    logic                done;
    logic [2*W-1:0]      product;

    int    n_checks = 0;
    int    n_errors = 0;
    int    cyc = 0;
    string cur_tag = "R11";

    // Behavioural model state
    bit                    m_seen = 0;
    bit                    m_run = 0;
    bit                    m_done = 0;
    bit                    m_have = 1;
    int                    m_cnt = 0;
    logic signed [2*W-1:0] m_prod = '0;
    logic signed [2*W-1:0] m_pend = '0;

    always #4 clk = ~clk;

    booth_mult #(.WIDTH(W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op_mcand  (a),
        .op_mplier (b),
        .done      (done),
        .product   (product)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Reference model, one step per rising edge
    always @(posedge clk) begin
        m_seen = 1;
        if (!rst_n) begin
            m_run = 0; m_cnt = 0; m_done = 0; m_prod = '0; m_have = 1;
        end else begin
            m_done = 0;
            if (m_run) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_run = 0; m_done = 1; m_prod = m_pend; m_have = 1;
                end
            end else if (start) begin
                m_run = 1; m_cnt = W; m_have = 0;
                m_pend = 2*W'(a) * 2*W'(b);
                m_pend = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
            end
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (m_seen) begin
            check(done === m_done, "R7 done", longint'(done), longint'(m_done));
            if (m_have)
                check(product === m_prod, cur_tag, longint'($signed(product)), longint'(m_prod));
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000) begin
            n_errors++;
            $display("FAIL watchdog: actual %0d expected below 200000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic launch(input logic signed [W-1:0] x, input logic signed [W-1:0] y, input string tag);
        cur_tag = tag;
        a = x; b = y; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (done !== 1'b1 && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        check(guard < 100, "R6 timeout", guard, W);
    endtask

    task automatic run_op(input logic signed [W-1:0] x, input logic signed [W-1:0] y, input string tag);
        launch(x, y, tag);
        wait_done();
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(done === 1'b0, "R11 done", longint'(done), 0);
        check(product === '0, "R11 product", longint'(product), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(8'sd55, 8'sd0, "R2");          // multiplier zero: only 00 pairs
        run_op(-8'sd3, -8'sd1, "R4");         // 10 then 11 pairs
        run_op(8'sd37, 8'sd85, "R3");         // alternating 01/10 pairs
        run_op(8'sd127, 8'sd127, "R5");
        run_op(-8'sd1, -8'sd1, "R5");
        run_op(-8'sd128, -8'sd128, "R9");     // expect +16384
        run_op(-8'sd128, 8'sd127, "R9");      // expect -16256
        run_op(8'sd127, -8'sd128, "R9");

        // R10: start mid-run with other operands must be dropped
        launch(8'sd19, -8'sd7, "R10");
        repeat (3) @(negedge clk);
        a = 8'sd100; b = 8'sd100; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        // R1: start accepted during the done cycle
        launch(-8'sd45, 8'sd66, "R1");
        wait_done();
        repeat (4) @(negedge clk);            // R8: idle hold checked each cycle

        for (int i = 0; i < 200; i++)
            run_op($urandom, $urandom, "R6");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule